// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block keeps the routing table of an interrupt router. Each of its entries is 64 bits wide and is stored as two 32-bit words. A host reaches every register through a single pair of locations. First it writes an 8-bit register offset into the pointer location. It then reads or writes the 32-bit register at that offset through the window location. A read-only identification register reports the version number of the block and the highest entry number of the table. Software can use it to size the table before it programs any entry.

Every entry's fields are also presented as decoded outputs for downstream logic: the vector, the delivery mode, the destination addressing mode, the input polarity, the trigger type, the mask bit and the destination byte. Bus arbitration, sensing of interrupt inputs and message delivery belong to other blocks.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset, every entry has its mask bit at 1 and all of its other fields at 0, and the pointer register reads as 0.
- R2: A write to the pointer location (host_sel_data = 0) keeps only bits 7:0 of the write data. A read of the pointer location returns those 8 bits, zero-extended.
- R3: A window write while the pointer holds 0x10 + 2n updates the low word of entry n on the next rising edge. The fields are vector in bits 7:0, delivery mode in bits 10:8, addressing mode in bit 11, polarity in bit 13, trigger type in bit 15 and mask in bit 16. A read of that word returns these fields with every other bit as 0.
- R4: A window write while the pointer holds 0x11 + 2n sets the destination of entry n from data bits 31:24. A read of that word returns the destination in bits 31:24 and 0 in bits 23:0.
- R5: A window read at offset 0x01 returns the entry count minus one in bits 23:16 and the version 0x11 in bits 7:0, with all other bits 0. With 24 entries the value is 0x00170011.
- R6: Window reads at an offset that is neither 0x01 nor inside the table (such as 0x00, 0x0F, 0x40 or 0xFF) return 0. Window writes to such offsets change no entry output.
- R7: A window write at offset 0x01 leaves both the identification register and every entry unchanged.
- R8: A write to one entry word changes no field of any other entry. When no write is presented, no entry output changes.
- R9: Read data and host_rvalid appear exactly one cycle after a host_rd strobe. host_rvalid is 1 only in that cycle.
- R10: Rewriting a masked entry's low word with only bit 16 cleared re-enables it: the mask output drops to 0 and every other field of that entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Write strobe for one cycle |
| host_rd | input | 1 | Read strobe for one cycle |
| host_sel_data | input | 1 | 0 selects the pointer location, 1 selects the window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while host_rvalid is 1 |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| ent_vector | output | NUM_ENTRIES*8 | Vector of each entry, entry n in bits 8n+7:8n |
| ent_dlv_mode | output | NUM_ENTRIES*3 | Delivery mode of each entry, entry n in bits 3n+2:3n |
| ent_dst_logical | output | NUM_ENTRIES | Addressing mode per entry, 1 = logical |
| ent_pol_low | output | NUM_ENTRIES | Input polarity per entry, 1 = active low |
| ent_trig_level | output | NUM_ENTRIES | Trigger type per entry, 1 = level |
| ent_mask | output | NUM_ENTRIES | Mask per entry, 1 = no interrupt may be produced |
| ent_dest | output | NUM_ENTRIES*8 | Destination byte of each entry, entry n in bits 8n+7:8n |

## Verification
Entry outputs and the pointer register take a new value on the rising edge that samples the write strobe. The bench drives every strobe 1 ns after a rising edge and compares the decoded outputs with its model once that edge has passed and the task has returned. Read data is registered, so it is due one cycle after host_rd. The read task pushes the expected word into a queue when it raises the strobe. A monitor pops the queue on the falling edge that follows each rising edge where host_rvalid is high, and it treats an unexpected valid or a word left in the queue as a mismatch.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned VEC_W  = 8;
   localparam int unsigned DLV_W  = 3;
   localparam int unsigned DEST_W = 8;

   // bit positions inside the low / high word of an entry
   localparam int unsigned VEC_LSB    = 0;
   localparam int unsigned DLV_LSB    = 8;
   localparam int unsigned DMODE_BIT  = 11;
   localparam int unsigned POL_BIT    = 13;
   localparam int unsigned TRIG_BIT   = 15;
   localparam int unsigned MASK_BIT   = 16;
   localparam int unsigned DEST_LSB   = 24;
   localparam int unsigned MAXENT_LSB = 16;

   typedef struct packed {
      logic             mask;
      logic             trig;
      logic             pol;
      logic             dmode;
      logic [DLV_W-1:0] dlv;
      logic [VEC_W-1:0] vec;
   } lo_fields_t;

   typedef enum logic {
      SEL_POINTER = 1'b0,
      SEL_WINDOW  = 1'b1
   } host_sel_e;

   function automatic lo_fields_t lo_unpack(input logic [WORD_W-1:0] w);
      lo_fields_t f;
      f.vec   = w[VEC_LSB +: VEC_W];
      f.dlv   = w[DLV_LSB +: DLV_W];
      f.dmode = w[DMODE_BIT];
      f.pol   = w[POL_BIT];
      f.trig  = w[TRIG_BIT];
      f.mask  = w[MASK_BIT];
      return f;
   endfunction

   function automatic logic [WORD_W-1:0] lo_pack(input lo_fields_t f);
      logic [WORD_W-1:0] w;
      w                    = '0;
      w[VEC_LSB +: VEC_W]  = f.vec;
      w[DLV_LSB +: DLV_W]  = f.dlv;
      w[DMODE_BIT]         = f.dmode;
      w[POL_BIT]           = f.pol;
      w[TRIG_BIT]          = f.trig;
      w[MASK_BIT]          = f.mask;
      return w;
   endfunction

endpackage

// File: rtl/irq_rf_pointer.sv
module irq_rf_pointer
   import irq_rf_pkg::*;
#(
   parameter int unsigned OFS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_ofs,
   output logic [OFS_W-1:0]  ptr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_en) begin
         ptr_q <= wr_ofs;
      end
   end

endmodule

// File: rtl/irq_rf_entry.sv
module irq_rf_entry
   import irq_rf_pkg::*;
#(
   parameter bit MASK_AT_RESET = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [WORD_W-1:0]  wdata,
   output lo_fields_t         fld,
   output logic [DEST_W-1:0]  dest,
   output logic [WORD_W-1:0]  lo_word,
   output logic [WORD_W-1:0]  hi_word
);

   lo_fields_t        fld_q;
   logic [DEST_W-1:0] dest_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q      <= '0;
         fld_q.mask <= MASK_AT_RESET;
         dest_q     <= '0;
      end else begin
         if (wr_lo) begin
            fld_q <= lo_unpack(wdata);
         end
         if (wr_hi) begin
            dest_q <= wdata[DEST_LSB +: DEST_W];
         end
      end
   end

   // reserved low-word bits are not stored
   logic wdata_unused;
   assign wdata_unused = ^{wdata[DEST_LSB-1:MASK_BIT+1], wdata[TRIG_BIT-1], wdata[POL_BIT-1]};

   assign fld     = fld_q;
   assign dest    = dest_q;
   assign lo_word = lo_pack(fld_q);

   always_comb begin
      hi_word                      = '0;
      hi_word[DEST_LSB +: DEST_W]  = dest_q;
   end

endmodule

// File: rtl/irq_rf_readmux.sv
module irq_rf_readmux
   import irq_rf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 24,
   parameter int unsigned OFS_W       = 8,
   parameter int unsigned TABLE_BASE  = 16,
   parameter int unsigned VER_OFFSET  = 1,
   parameter logic [7:0]  VERSION_ID  = 8'h11
) (
   input  logic                                  sel_window,
   input  logic [OFS_W-1:0]                      ptr,
   input  logic [NUM_ENTRIES-1:0][WORD_W-1:0]    lo_words,
   input  logic [NUM_ENTRIES-1:0][WORD_W-1:0]    hi_words,
   output logic [WORD_W-1:0]                     rdata
);

   typedef logic [OFS_W-1:0] ofs_t;

   localparam logic [WORD_W-1:0] ID_WORD =
      (WORD_W'(NUM_ENTRIES - 1) << MAXENT_LSB) | WORD_W'(VERSION_ID);

   always_comb begin
      rdata = '0;
      if (!sel_window) begin
         rdata[OFS_W-1:0] = ptr;
      end else if (ptr == ofs_t'(VER_OFFSET)) begin
         rdata = ID_WORD;
      end else begin
         for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
            if (ptr == ofs_t'(TABLE_BASE + 2*i)) begin
               rdata = lo_words[i];
            end
            if (ptr == ofs_t'(TABLE_BASE + 2*i + 1)) begin
               rdata = hi_words[i];
            end
         end
      end
   end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
   import irq_rf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES   = 24,
   parameter int unsigned OFS_W         = 8,
   parameter int unsigned TABLE_BASE    = 16,
   parameter int unsigned VER_OFFSET    = 1,
   parameter logic [7:0]  VERSION_ID    = 8'h11,
   parameter bit          MASK_AT_RESET = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            host_wr,
   input  logic                            host_rd,
   input  logic                            host_sel_data,
   input  logic [WORD_W-1:0]               host_wdata,
   output logic [WORD_W-1:0]               host_rdata,
   output logic                            host_rvalid,
   output logic [NUM_ENTRIES*VEC_W-1:0]    ent_vector,
   output logic [NUM_ENTRIES*DLV_W-1:0]    ent_dlv_mode,
   output logic [NUM_ENTRIES-1:0]          ent_dst_logical,
   output logic [NUM_ENTRIES-1:0]          ent_pol_low,
   output logic [NUM_ENTRIES-1:0]          ent_trig_level,
   output logic [NUM_ENTRIES-1:0]          ent_mask,
   output logic [NUM_ENTRIES*DEST_W-1:0]   ent_dest
);

   typedef logic [OFS_W-1:0] ofs_t;

   localparam int unsigned TABLE_END = TABLE_BASE + 2*NUM_ENTRIES;

   // elaboration-time parameter checks
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 256) begin : g_bad_entries
      $error("irq_route_regfile: NUM_ENTRIES must lie in 1..256");
   end
   if (OFS_W > WORD_W || OFS_W < 2) begin : g_bad_ofs_w
      $error("irq_route_regfile: OFS_W must lie in 2..32");
   end
   if (TABLE_END > (1 << OFS_W)) begin : g_bad_span
      $error("irq_route_regfile: table does not fit in the offset space");
   end
   if (VER_OFFSET >= TABLE_BASE && VER_OFFSET < TABLE_END) begin : g_bad_ver
      $error("irq_route_regfile: identification offset overlaps the table");
   end

   // pointer register
   logic ptr_wr;
   ofs_t ptr_q;

   assign ptr_wr = host_wr && (host_sel_e'(host_sel_data) == SEL_POINTER);

   irq_rf_pointer #(
      .OFS_W (OFS_W)
   ) u_pointer (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ptr_wr),
      .wr_ofs (host_wdata[OFS_W-1:0]),
      .ptr_q  (ptr_q)
   );

   // entry storage
   logic                                 win_wr;
   logic [NUM_ENTRIES-1:0]               wr_lo;
   logic [NUM_ENTRIES-1:0]               wr_hi;
   logic [NUM_ENTRIES-1:0][WORD_W-1:0]   lo_words;
   logic [NUM_ENTRIES-1:0][WORD_W-1:0]   hi_words;
   lo_fields_t                           fld [NUM_ENTRIES];
   logic [DEST_W-1:0]                    dest [NUM_ENTRIES];

   assign win_wr = host_wr && (host_sel_e'(host_sel_data) == SEL_WINDOW);

   for (genvar i = 0; i < int'(NUM_ENTRIES); i++) begin : g_entry
      assign wr_lo[i] = win_wr && (ptr_q == ofs_t'(TABLE_BASE + 2*i));
      assign wr_hi[i] = win_wr && (ptr_q == ofs_t'(TABLE_BASE + 2*i + 1));

      irq_rf_entry #(
         .MASK_AT_RESET (MASK_AT_RESET)
      ) u_entry (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo   (wr_lo[i]),
         .wr_hi   (wr_hi[i]),
         .wdata   (host_wdata),
         .fld     (fld[i]),
         .dest    (dest[i]),
         .lo_word (lo_words[i]),
         .hi_word (hi_words[i])
      );

      assign ent_vector[i*VEC_W +: VEC_W]    = fld[i].vec;
      assign ent_dlv_mode[i*DLV_W +: DLV_W]  = fld[i].dlv;
      assign ent_dst_logical[i]              = fld[i].dmode;
      assign ent_pol_low[i]                  = fld[i].pol;
      assign ent_trig_level[i]               = fld[i].trig;
      assign ent_mask[i]                     = fld[i].mask;
      assign ent_dest[i*DEST_W +: DEST_W]    = dest[i];
   end

   // read path
   logic [WORD_W-1:0] rd_mux;

   irq_rf_readmux #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .OFS_W       (OFS_W),
      .TABLE_BASE  (TABLE_BASE),
      .VER_OFFSET  (VER_OFFSET),
      .VERSION_ID  (VERSION_ID)
   ) u_readmux (
      .sel_window (host_sel_data),
      .ptr        (ptr_q),
      .lo_words   (lo_words),
      .hi_words   (hi_words),
      .rdata      (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
      end else begin
         host_rvalid <= host_rd;
         if (host_rd) begin
            host_rdata <= rd_mux;
         end
      end
   end

endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk
   import irq_rf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 24,
   parameter int unsigned OFS_W       = 8,
   parameter int unsigned TABLE_BASE  = 16,
   parameter int unsigned VER_OFFSET  = 1,
   parameter logic [7:0]  VERSION_ID  = 8'h11
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           host_wr,
   input logic                           host_rd,
   input logic                           host_sel_data,
   input logic [OFS_W-1:0]               host_wofs,
   input logic [WORD_W-1:0]              host_rdata,
   input logic                           host_rvalid,
   input logic [OFS_W-1:0]               ptr_q,
   input logic [NUM_ENTRIES*VEC_W-1:0]   ent_vector,
   input logic [NUM_ENTRIES*DLV_W-1:0]   ent_dlv_mode,
   input logic [NUM_ENTRIES-1:0]         ent_dst_logical,
   input logic [NUM_ENTRIES-1:0]         ent_pol_low,
   input logic [NUM_ENTRIES-1:0]         ent_trig_level,
   input logic [NUM_ENTRIES-1:0]         ent_mask,
   input logic [NUM_ENTRIES*DEST_W-1:0]  ent_dest
);

   localparam logic [WORD_W-1:0] EXP_ID =
      {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION_ID};

   logic in_table;
   logic at_id;
   logic win_wr;
   logic win_rd;

   assign in_table = (32'(ptr_q) >= TABLE_BASE) && (32'(ptr_q) < TABLE_BASE + 2*NUM_ENTRIES);
   assign at_id    = (32'(ptr_q) == VER_OFFSET);
   assign win_wr   = host_wr && host_sel_data;
   assign win_rd   = host_rd && host_sel_data;

   p_rvalid_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> host_rvalid);

   p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> !host_rvalid);

   p_pointer_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_sel_data) |=> (ptr_q == $past(host_wofs)));

   p_pointer_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_sel_data && !host_wr) |=> (host_rdata == WORD_W'($past(ptr_q))));

   p_id_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd && at_id) |=> (host_rdata == EXP_ID));

   p_unmapped_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd && !at_id && !in_table) |=> (host_rdata == '0));

   p_stray_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && !in_table && !at_id) |=> ($stable(ent_vector) && $stable(ent_dlv_mode) &&
         $stable(ent_dst_logical) && $stable(ent_pol_low) && $stable(ent_trig_level) &&
         $stable(ent_mask) && $stable(ent_dest)));

   p_id_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && at_id) |=> ($stable(ent_vector) && $stable(ent_mask) && $stable(ent_dest) &&
         $stable(ent_dlv_mode) && $stable(ent_trig_level)));

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> ($stable(ent_vector) && $stable(ent_dlv_mode) && $stable(ent_dst_logical) &&
         $stable(ent_pol_low) && $stable(ent_trig_level) && $stable(ent_mask) && $stable(ent_dest)));

   p_pointer_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_sel_data) |=> ($stable(ent_vector) && $stable(ent_mask) && $stable(ent_dest)));

endmodule

bind irq_route_regfile irq_route_regfile_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .OFS_W       (OFS_W),
   .TABLE_BASE  (TABLE_BASE),
   .VER_OFFSET  (VER_OFFSET),
   .VERSION_ID  (VERSION_ID)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .host_wr         (host_wr),
   .host_rd         (host_rd),
   .host_sel_data   (host_sel_data),
   .host_wofs       (host_wdata[OFS_W-1:0]),
   .host_rdata      (host_rdata),
   .host_rvalid     (host_rvalid),
   .ptr_q           (ptr_q),
   .ent_vector      (ent_vector),
   .ent_dlv_mode    (ent_dlv_mode),
   .ent_dst_logical (ent_dst_logical),
   .ent_pol_low     (ent_pol_low),
   .ent_trig_level  (ent_trig_level),
   .ent_mask        (ent_mask),
   .ent_dest        (ent_dest)
);

// File: tb/irq_route_regfile_bench.sv
module irq_route_regfile_bench;

   localparam int N          = 24;
   localparam int BASE       = 16;
   localparam int MAX_CYCLES = 20000;
   localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;   // bits 16,15,13,11,10:8,7:0
   localparam logic [31:0] HI_KEEP = 32'hFF00_0000;   // bits 31:24
   localparam logic [31:0] ID_EXP  = 32'h0017_0011;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic          host_sel_data = 1'b0;
   logic [31:0]   host_wdata = '0;
   logic [31:0]   host_rdata;
   logic          host_rvalid;
   logic [N*8-1:0] ent_vector;
   logic [N*3-1:0] ent_dlv_mode;
   logic [N-1:0]   ent_dst_logical;
   logic [N-1:0]   ent_pol_low;
   logic [N-1:0]   ent_trig_level;
   logic [N-1:0]   ent_mask;
   logic [N*8-1:0] ent_dest;

   always #4 clk = ~clk;   // 125 MHz

   irq_route_regfile u_irq_route_regfile (
      .clk             (clk),
      .rst_n           (rst_n),
      .host_wr         (host_wr),
      .host_rd         (host_rd),
      .host_sel_data   (host_sel_data),
      .host_wdata      (host_wdata),
      .host_rdata      (host_rdata),
      .host_rvalid     (host_rvalid),
      .ent_vector      (ent_vector),
      .ent_dlv_mode    (ent_dlv_mode),
      .ent_dst_logical (ent_dst_logical),
      .ent_pol_low     (ent_pol_low),
      .ent_trig_level  (ent_trig_level),
      .ent_mask        (ent_mask),
      .ent_dest        (ent_dest)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_lo [N];
   logic [31:0] m_hi [N];
   logic [7:0]  m_ptr;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: read data is due one cycle after the strobe
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            check("R9 unexpected rvalid", 32'd1, 32'd0);
         end else begin
            check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
         end
      end
   end

   function automatic logic [31:0] model_read(input logic [7:0] ofs);
      int rel;
      rel = int'(ofs) - BASE;
      if (ofs == 8'h01) return ID_EXP;
      if (rel >= 0 && rel < 2*N) return rel[0] ? m_hi[rel/2] : m_lo[rel/2];
      return 32'h0;
   endfunction

   task automatic bus_write(input logic sel, input logic [31:0] data);
      @(posedge clk); #1;
      host_wr = 1'b1; host_sel_data = sel; host_wdata = data;
      @(posedge clk); #1;
      host_wr = 1'b0;
      if (!sel) begin
         m_ptr = data[7:0];
      end else begin
         int rel;
         rel = int'(m_ptr) - BASE;
         if (rel >= 0 && rel < 2*N) begin
            if (rel[0]) m_hi[rel/2] = data & HI_KEEP;
            else        m_lo[rel/2] = data & LO_KEEP;
         end
      end
   endtask

   task automatic bus_read(input logic sel, input string tag);
      @(posedge clk); #1;
      host_rd = 1'b1; host_sel_data = sel;
      exp_q.push_back(sel ? model_read(m_ptr) : {24'h0, m_ptr});
      tag_q.push_back(tag);
      @(posedge clk); #1;
      host_rd = 1'b0;
   endtask

   task automatic win_write(input logic [7:0] ofs, input logic [31:0] data);
      bus_write(1'b0, {24'h0, ofs});
      bus_write(1'b1, data);
   endtask

   task automatic win_read(input logic [7:0] ofs, input string tag);
      bus_write(1'b0, {24'h0, ofs});
      bus_read(1'b1, tag);
   endtask

   task automatic check_entry(input string req, input int i);
      logic [31:0] act, exp;
      act = {2'b0, ent_dest[i*8 +: 8], 7'b0, ent_mask[i], ent_trig_level[i], ent_pol_low[i],
             ent_dst_logical[i], ent_dlv_mode[i*3 +: 3], ent_vector[i*8 +: 8]};
      exp = {2'b0, m_hi[i][31:24], 7'b0, m_lo[i][16], m_lo[i][15], m_lo[i][13],
             m_lo[i][11], m_lo[i][10:8], m_lo[i][7:0]};
      check($sformatf("%s entry %0d fields", req, i), act, exp);
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < N; i++) check_entry(req, i);
   endtask

   initial begin
      #(MAX_CYCLES * 8);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_lo[i] = 32'h0001_0000;
         m_hi[i] = 32'h0;
      end
      m_ptr = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      check_all("R1");
      bus_read(1'b0, "R1 pointer after reset");
      win_read(8'(BASE + 20), "R1 low word after reset");

      // R2: pointer keeps only its low 8 bits
      bus_write(1'b0, 32'h0000_01AB);
      bus_read(1'b0, "R2 pointer readback");

      // R5: identification register
      win_read(8'h01, "R5 identification word");

      // R7: writes to the identification register are ignored
      win_write(8'h01, 32'hFFFF_FFFF);
      check_all("R7");
      bus_read(1'b1, "R7 identification after write");

      // R3: low word of entry 0, all bits set
      win_write(8'(BASE), 32'hFFFF_FFFF);
      check_entry("R3", 0);
      bus_read(1'b1, "R3 low word readback");

      // R4: high word of the last entry
      win_write(8'(BASE + 2*N - 1), 32'hFFFF_FFFF);
      check_entry("R4", N - 1);
      bus_read(1'b1, "R4 high word readback");

      // R9: no valid while idle
      repeat (2) @(posedge clk);
      #1 check("R9 idle rvalid", {31'h0, host_rvalid}, 32'h0);

      // R8: distinct patterns in every entry, no crosstalk
      for (int i = 0; i < N; i++) begin
         win_write(8'(BASE + 2*i), 32'h5A00_0000 ^ (32'(i) * 32'h0000_1357));
         win_write(8'(BASE + 2*i + 1), {8'(i * 11 + 3), 24'hC3C3C3});
      end
      check_all("R8");
      for (int i = 0; i < N; i += 5) begin
         win_read(8'(BASE + 2*i), "R3 pattern low readback");
         win_read(8'(BASE + 2*i + 1), "R4 pattern high readback");
      end

      // R10: masked entry re-enabled by clearing only the mask bit
      win_write(8'(BASE + 20), 32'h0001_2B6C);
      check_entry("R10 masked", 10);
      win_write(8'(BASE + 20), 32'h0000_2B6C);
      check("R10 mask cleared", {31'h0, ent_mask[10]}, 32'h0);
      check_all("R10");

      // R6: unmapped offsets
      win_write(8'h40, 32'hFFFF_FFFF);
      win_write(8'h00, 32'hFFFF_FFFF);
      win_write(8'h0F, 32'hFFFF_FFFF);
      win_write(8'hFF, 32'hFFFF_FFFF);
      check_all("R6");
      win_read(8'h40, "R6 read 0x40");
      win_read(8'h00, "R6 read 0x00");
      win_read(8'h0F, "R6 read 0x0F");
      win_read(8'hFF, "R6 read 0xFF");

      repeat (3) @(posedge clk);
      #1 check("R9 reads left unanswered", 32'(exp_q.size()), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule